// File: doc/BRIEF.md
# Programmable Bit Clock Divider

This block turns a fast reference clock into a slower serial audio bit clock. The ratio is a programmable integer held in an unsigned divisor field of `DIV_W` bits. With the default of 10 bits, the ratio can be any value from 2 to 1024. A field value of zero selects the largest ratio, 2^`DIV_W`. A field value of one is refused. The generated clock `bclk` is a register output. Every change of `bclk` comes with a one-cycle `edge_stb` pulse, so downstream serial logic can act on bit-clock transitions while staying in the reference domain.

Software writes a 32-bit control word. The divisor sits in the low `DIV_W` bits, and all bits above the field are ignored. A phase-selection flag is written in the same write. Both values go to staging registers only. A `load` strobe takes a snapshot of the staged values. The running divider adopts that snapshot at the end of its current output period, so no phase is ever cut short. Every output period begins with its low phase. For an odd ratio, the flag decides which phase gets the extra reference cycle.

With a 48 MHz reference and the maximum ratio of 1024, the output is 46.875 kHz.

Top module: `bclk_divider`

## Requirements
- R1: Each output period lasts exactly `ratio` reference cycles and begins with its low phase (the boundary is a falling edge), for every field value from 2 to 2^`DIV_W`-1.
- R2: A field value of 0 gives a ratio of 2^`DIV_W` (1024 with the default width).
- R3: For an even ratio, the low phase and the high phase each last ratio/2 cycles.
- R4: For an odd ratio with the phase flag at 0, the low phase is one cycle longer than the high phase: low = (ratio+1)/2.
- R5: For an odd ratio with the phase flag at 1, the high phase is one cycle longer than the low phase: high = (ratio+1)/2.
- R6: A load while the staged field holds 1 is refused. The active ratio and phase are kept, and `load_err` is 1 from the next cycle. `load_err` returns to 0 after the next accepted load.
- R7: A write changes only the staging registers. The output timing does not change until a load is given.
- R8: An accepted load takes effect at the next period boundary. The period in progress completes with its old phase lengths.
- R9: `edge_stb` is 1 for exactly the cycles in which `bclk` differs from its value one cycle earlier.
- R10: After reset, `bclk` and `load_err` are 0, `cfg_rdata` is 0, the phase flag is 0, and the ratio is 2^`DIV_W`.
- R11: `cfg_rdata` returns the staged field in bits `DIV_W`-1:0 and zero in every bit above it. Bits of `cfg_wdata` above the field have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the staging registers |
| cfg_wdata | input | 32 | Control word; the divisor field is in the low DIV_W bits |
| cfg_phase_hi | input | 1 | Phase flag written with cfg_we; 1 puts the extra odd cycle in the high phase |
| load | input | 1 | Snapshot the staged values for the next period boundary |
| cfg_rdata | output | 32 | Staged divisor field, with zeros above it |
| bclk | output | 1 | Divided bit clock |
| edge_stb | output | 1 | One-cycle pulse when bclk has just changed |
| load_err | output | 1 | The last load was refused because the divisor was 1 |

## Verification
A wrong counter or a stale active ratio shows up within a single output period as a phase length that differs from the arithmetic in R1 to R5. The bench therefore measures the low and high run lengths of `bclk` for every field value and both flag settings of a 5-bit configuration. A pending load that is lost, or applied too early, shows up in the period that straddles the load: that period's high run must keep the old length. A strobe that slips by one cycle is caught on the very cycle it appears, because `edge_stb` is compared against the observed change of `bclk` on every cycle.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned RATIO_W = 16;  // holds 2**DIV_W for DIV_W <= 15

  typedef struct packed {
    logic               phase_hi;
    logic [RATIO_W-1:0] ratio;
  } div_cfg_t;

  // field value -> ratio in reference cycles; zero means the full 2**w
  function automatic logic [RATIO_W-1:0] field_to_ratio(input logic [RATIO_W-1:0] field,
                                                        input int unsigned w);
    return (field == '0) ? (RATIO_W'(1) << w) : field;
  endfunction

  // number of reference cycles the output spends low in one period
  function automatic logic [RATIO_W-1:0] low_cycles(input logic [RATIO_W-1:0] ratio,
                                                    input logic phase_hi);
    return (ratio >> 1) + {{(RATIO_W-1){1'b0}}, ratio[0] & ~phase_hi};
  endfunction

endpackage

// File: rtl/bclk_cfg.sv
module bclk_cfg
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cfg_phase_hi,
  input  logic              load,
  input  logic              applied,
  output logic              pend_valid,
  output div_cfg_t          pend_cfg,
  output logic              load_err,
  output logic [WORD_W-1:0] cfg_rdata
);

  localparam int unsigned PAD_W = RATIO_W - DIV_W;

  logic [DIV_W-1:0] stg_div;
  logic             stg_phase;
  logic             bad_load;
  logic [RATIO_W-1:0] stg_ratio;

  assign bad_load  = load && (stg_div == DIV_W'(1));
  assign stg_ratio = field_to_ratio({{PAD_W{1'b0}}, stg_div}, DIV_W);
  assign cfg_rdata = {{(WORD_W-DIV_W){1'b0}}, stg_div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_div    <= '0;
      stg_phase  <= 1'b0;
      pend_valid <= 1'b0;
      pend_cfg   <= '0;
      load_err   <= 1'b0;
    end else begin
      if (cfg_we) begin
        stg_div   <= DIV_W'(cfg_wdata);
        stg_phase <= cfg_phase_hi;
      end
      if (bad_load) begin
        load_err <= 1'b1;
      end else if (load) begin
        load_err   <= 1'b0;
        pend_valid <= 1'b1;
        pend_cfg   <= '{phase_hi: stg_phase, ratio: stg_ratio};
      end else if (applied) begin
        pend_valid <= 1'b0;
      end
    end
  end

  // R6: a refused load raises the error flag
  p_reject_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_load |=> load_err);
  // R6: a refused load creates no pending change
  p_reject_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_load && !pend_valid) |=> !pend_valid);
  // R7: a pending change only appears after a load
  p_stage_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pend_valid) |=> !pend_valid);

endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pend_valid,
  input  div_cfg_t pend_cfg,
  output logic     applied,
  output logic     bclk,
  output logic     edge_stb
);

  localparam logic [RATIO_W-1:0] MAX_RATIO = RATIO_W'(1) << DIV_W;

  div_cfg_t           act_q, act_nxt;
  logic [RATIO_W-1:0] cnt_q, cnt_nxt;
  logic               period_end;
  logic               out_nxt;

  assign period_end = (cnt_q == act_q.ratio - RATIO_W'(1));
  assign applied    = period_end && pend_valid;
  assign act_nxt    = applied ? pend_cfg : act_q;
  assign cnt_nxt    = period_end ? '0 : cnt_q + RATIO_W'(1);
  assign out_nxt    = (cnt_nxt >= low_cycles(act_nxt.ratio, act_nxt.phase_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '{phase_hi: 1'b0, ratio: MAX_RATIO};
      cnt_q    <= '0;
      bclk     <= 1'b0;
      edge_stb <= 1'b0;
    end else begin
      act_q    <= act_nxt;
      cnt_q    <= cnt_nxt;
      bclk     <= out_nxt;
      edge_stb <= (out_nxt != bclk);
    end
  end

  // R1: counter never leaves the active period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q.ratio);
  // R1: every period starts low
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !bclk);
  // R2: active ratio stays within the legal range
  p_ratio_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.ratio >= RATIO_W'(2)) && (act_q.ratio <= MAX_RATIO));
  // R8: active settings change only at a period boundary
  p_hold_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_q));
  // R9: strobe marks exactly the cycles where the output changed
  p_edge_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb == (bclk != $past(bclk)));

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
  import bclk_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_phase_hi,
  input  logic        load,
  output logic [31:0] cfg_rdata,
  output logic        bclk,
  output logic        edge_stb,
  output logic        load_err
);

  logic     pend_valid;
  div_cfg_t pend_cfg;
  logic     applied;

  bclk_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_phase_hi (cfg_phase_hi),
    .load         (load),
    .applied      (applied),
    .pend_valid   (pend_valid),
    .pend_cfg     (pend_cfg),
    .load_err     (load_err),
    .cfg_rdata    (cfg_rdata)
  );

  bclk_gen #(.DIV_W(DIV_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_valid (pend_valid),
    .pend_cfg   (pend_cfg),
    .applied    (applied),
    .bclk       (bclk),
    .edge_stb   (edge_stb)
  );

  // R8: a pending change is consumed only at a period boundary
  p_apply_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    applied |=> !bclk);

endmodule

// File: tb/tb_bclk_divider.sv
module tb_bclk_divider;

  localparam int unsigned W = 5;
  localparam int MAXR = 1 << W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_phase_hi = 1'b0;
  logic        load = 1'b0;
  logic [31:0] cfg_rdata;
  logic        bclk, edge_stb, load_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bclk_divider #(.DIV_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_phase_hi(cfg_phase_hi), .load(load), .cfg_rdata(cfg_rdata),
    .bclk(bclk), .edge_stb(edge_stb), .load_err(load_err)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9: strobe compared with the observed change of bclk on every cycle
  logic prev_out = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 edge_stb", int'(edge_stb), int'(bclk != prev_out));
      prev_out = bclk;
    end
  end

  task automatic write_cfg(input logic [31:0] word, input logic ph);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = word; cfg_phase_hi = ph;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0; cfg_phase_hi = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic wait_level(input logic v);
    do @(negedge clk); while (bclk != v);
  endtask

  // waits for a period boundary, then counts low and high runs
  task automatic measure(output int lo, output int hi);
    wait_level(1'b1);
    wait_level(1'b0);
    lo = 1;
    forever begin @(negedge clk); if (bclk) break; lo++; end
    hi = 1;
    forever begin @(negedge clk); if (!bclk) break; hi++; end
  endtask

  function automatic int exp_low(input int r, input bit ph);
    return r / 2 + ((r % 2 == 1 && !ph) ? 1 : 0);
  endfunction

  task automatic check_period(input string req, input int r, input bit ph);
    int lo, hi;
    measure(lo, hi);
    check({req, " low"}, lo, exp_low(r, ph));
    check({req, " high"}, hi, r - exp_low(r, ph));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 bclk", int'(bclk), 0);
    check("R10 load_err", int'(load_err), 0);
    check("R10 rdata", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    check_period("R10 reset ratio", MAXR, 1'b0);

    // R1..R5: sweep all field values and both phase flags
    for (int ph = 0; ph < 2; ph++) begin
      for (int d = 0; d < MAXR; d++) begin
        int r;
        string tag;
        if (d == 1) continue;
        r = (d == 0) ? MAXR : d;
        if (d == 0) tag = "R2";
        else if (r % 2 == 0) tag = "R3";
        else if (ph == 0) tag = "R4";
        else tag = "R5";
        write_cfg(32'(d), ph[0]);
        pulse_load();
        wait_level(1'b0);
        measure(lo, hi);
        check({tag, " R1 low"}, lo, exp_low(r, ph[0]));
        check({tag, " R1 high"}, hi, r - exp_low(r, ph[0]));
      end
    end

    // R11: bits above the field ignored and read as zero
    write_cfg(32'hFFFF_FFE7, 1'b0);
    @(negedge clk);
    check("R11 rdata", int'(cfg_rdata), 7);
    pulse_load();
    wait_level(1'b0);
    check_period("R11 ratio", 7, 1'b0);

    // R7: a write without a load leaves the timing alone
    write_cfg(32'd12, 1'b1);
    check_period("R7 unchanged", 7, 1'b0);
    check_period("R7 unchanged again", 7, 1'b0);

    // R6: divisor 1 refused, old ratio kept, flag raised then cleared
    write_cfg(32'd6, 1'b0);
    pulse_load();
    wait_level(1'b0);
    check_period("R6 setup", 6, 1'b0);
    write_cfg(32'd1, 1'b0);
    pulse_load();
    check("R6 flag set", int'(load_err), 1);
    check_period("R6 ratio kept", 6, 1'b0);
    check_period("R6 ratio kept again", 6, 1'b0);
    write_cfg(32'd9, 1'b1);
    pulse_load();
    check("R6 flag cleared", int'(load_err), 0);
    wait_level(1'b0);
    check_period("R6 accepted", 9, 1'b1);

    // R8: load in the middle of a high phase; that phase completes old
    write_cfg(32'd10, 1'b0);
    pulse_load();
    wait_level(1'b0);
    check_period("R8 setup", 10, 1'b0);
    write_cfg(32'd4, 1'b0);
    wait_level(1'b1);
    load = 1'b1;
    hi = 1;
    forever begin @(negedge clk); load = 1'b0; if (!bclk) break; hi++; end
    check("R8 old high kept", hi, 5);
    lo = 1;
    forever begin @(negedge clk); if (bclk) break; lo++; end
    check("R8 new low", lo, 2);
    hi = 1;
    forever begin @(negedge clk); if (!bclk) break; hi++; end
    check("R8 new high", hi, 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule